// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which interrupt a FIFO-equipped UART reports, and whether its interrupt line is raised. Once every `TICK_DIV` input clocks it looks at five candidate sources: receiver line errors, received data at or above the FIFO trigger level, a character timeout, transmit holding empty, and modem status change. It picks the highest one that is both pending and enabled. The chosen code is held in an identification register. The interrupt output stays registered until the next evaluation tick.

Error flags travel with each receive FIFO entry. On every tick where the FIFO is not empty, the unit folds the error byte of the head entry into a sticky line-status register. It pulses a clear request back to the FIFO in the same cycle. The block also contains two pieces of state. A character-timeout counter advances once per tick while data is ready, and its limit is a fixed multiple of the programmed character time. A transmit-empty pending flag is set when a byte leaves the holding buffer for the shift stage.

Bus strobes for reading the receive buffer, line status and identification register are accepted on any clock, so none is lost between ticks.

Top module: `uart_irq_ident`

## Requirements
- R1: `iid` and `irq` change only on the clock where the internal prescaler wraps, once every `TICK_DIV` (16) clocks counted from reset release. Between such ticks they hold.
- R2: When several sources qualify on a tick, the priority from highest to lowest is line status, receive data, timeout, transmit empty, modem status.
- R3: The line-status source needs `ier[2]` and any of status bits 1 (overrun), 2 (parity), 3 (framing) or 4 (break). Its code is 0x6.
- R4: The receive-data source needs `ier[0]`, `data_ready`, and `rx_count` at or above the trigger level. `trig_sel` values 0, 1, 2 and 3 select levels 1, 4, 8 and 14. Its code is 0x4.
- R5: The timeout counter adds one on each tick while `data_ready` is high, and `rx_read` clears it (clearing wins over counting). The timeout source needs `ier[0]` and a count at or above `TO_MULT` (4) times `char_time`. Its code is 0xC.
- R6: The transmit-empty source needs `ier[1]`, `thr_empty` and the pending flag. Its code is 0x2. `tx_load` sets the flag. `iid_read` clears it while `iid` shows 0x2. When both come in the same clock, setting wins.
- R7: The modem source needs `ier[3]` and any bit of `modem_delta`. Its code is 0x0.
- R8: On a tick with `rx_count` nonzero, bits 1, 2, 3, 4 and 7 of `head_status` are ORed into the sticky part of `lsr`, and `head_clr` is high in that same clock. Bits 0, 5 and 6 of `head_status` have no effect. `lsr` bits 0, 5 and 6 show `data_ready`, `thr_empty` and `tsr_empty` directly.
- R9: `lsr_read` clears the sticky `lsr` bits. If a merge happens in the same clock, the merged bits survive.
- R10: When no source qualifies, `iid` is 0x1 and `irq` is low. Otherwise `irq` is high.
- R11: After reset, `iid` is 0x1, `irq` is low, the sticky status bits are zero, and the timeout counter and pending flag are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier | input | 4 | Source enables: 0 receive/timeout, 1 transmit empty, 2 line status, 3 modem |
| trig_sel | input | 2 | Receive FIFO trigger level select |
| rx_count | input | FC_W (5) | Receive FIFO fill count |
| head_status | input | 8 | Error byte of the receive FIFO head entry |
| head_clr | output | 1 | Request to clear the head entry's error byte |
| char_time | input | CT_W (16) | Character time in ticks |
| data_ready | input | 1 | Receive data ready |
| thr_empty | input | 1 | Transmit holding buffer empty |
| tsr_empty | input | 1 | Transmit shift stage empty |
| modem_delta | input | 4 | Modem status change bits |
| tx_load | input | 1 | Byte moved from holding buffer to shift stage |
| rx_read | input | 1 | Receive buffer read strobe |
| lsr_read | input | 1 | Line-status read strobe |
| iid_read | input | 1 | Identification register read strobe |
| lsr | output | 8 | Line-status register view |
| iid | output | 4 | Interrupt identification code |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land on the same clock. A head-entry merge can coincide with a line-status read, and a `tx_load` can coincide with an identification read that would clear the pending flag. The bench lines each pair up on the clock its own tick model predicts as the evaluation tick. It then judges the result after that tick. For the first pair, the framing bit must stay visible in `lsr` and `iid` must stay 0x6. For the second pair, `iid` must still show 0x2. Random traffic also produces these collisions, and a cycle-by-cycle reference model built from the requirements scores them.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  typedef enum logic [3:0] {
    IID_MODEM = 4'h0,
    IID_NONE  = 4'h1,
    IID_TXE   = 4'h2,
    IID_RXD   = 4'h4,
    IID_LINE  = 4'h6,
    IID_TOUT  = 4'hC
  } iid_e;

  // enable bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // line-status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;

  // bits that stick until read, and the subset that raises a line interrupt
  localparam logic [7:0] STICKY_MASK   = 8'h9E;
  localparam logic [7:0] LINE_SRC_MASK = 8'h1E;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uiu_tick_gen.sv
module uiu_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc_q, presc_d;

  assign tick = (presc_q == LAST);

  always_comb begin
    presc_d = tick ? '0 : presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/uiu_char_timer.sv
module uiu_char_timer #(
  parameter int CT_W = 16,
  parameter int MULT = 4,
  parameter int CNT_W = CT_W + $clog2(MULT) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            data_ready,
  input  logic            rx_read,
  input  logic [CT_W-1:0] char_time,
  output logic            expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, thresh;

  assign thresh = CNT_W'(char_time) * CNT_W'(MULT);

  always_comb begin
    cnt_d = cnt_q;
    if (rx_read)
      cnt_d = '0;
    else if (tick && data_ready && (cnt_q != CNT_MAX))
      cnt_d = cnt_q + 1'b1;
  end

  assign expired = (cnt_d >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  tout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_read |=> (cnt_q == '0));

  // R5
  tout_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && data_ready && !rx_read && (cnt_q != CNT_MAX))
      |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/uiu_lsr_merge.sv
module uiu_lsr_merge
  import uart_iid_pkg::*;
#(
  parameter int FC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [FC_W-1:0] rx_count,
  input  logic [7:0]      head_status,
  input  logic            lsr_read,
  input  logic            data_ready,
  input  logic            thr_empty,
  input  logic            tsr_empty,
  output logic            head_clr,
  output logic [7:0]      err_next,
  output logic [7:0]      lsr
);
  logic [7:0] err_q, err_d, merged;
  logic       merge_go;

  assign merge_go = tick && (rx_count != '0);
  assign merged   = merge_go ? (head_status & STICKY_MASK) : 8'h00;
  assign head_clr = merge_go;

  always_comb begin
    err_d = (lsr_read ? 8'h00 : err_q) | merged;
  end

  assign err_next = err_d;

  always_comb begin
    lsr          = err_q;
    lsr[LS_DR]   = data_ready;
    lsr[LS_THRE] = thr_empty;
    lsr[LS_TEMT] = tsr_empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 8'h00;
    else        err_q <= err_d;
  end

  // R8
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    merge_go |=> ((err_q & $past(head_status & STICKY_MASK))
                  == $past(head_status & STICKY_MASK)));

  // R9
  lsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_read && !merge_go) |=> (err_q == 8'h00));

endmodule

// File: rtl/uiu_tx_pend.sv
module uiu_tx_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_load,
  input  logic ack,
  output logic pend_next
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (tx_load)  pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  assign pend_next = pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> pend_q);

  // R6
  pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tx_load) |=> !pend_q);

endmodule

// File: rtl/uiu_prio.sv
module uiu_prio
  import uart_iid_pkg::*;
#(
  parameter int FC_W = 5
) (
  input  logic [3:0]      ier,
  input  logic [7:0]      err,
  input  logic            data_ready,
  input  logic            thr_empty,
  input  logic [FC_W-1:0] rx_count,
  input  logic [1:0]      trig_sel,
  input  logic            expired,
  input  logic            pend,
  input  logic [3:0]      modem_delta,
  output iid_e            code
);
  logic [FC_W-1:0] trig_lvl;
  logic src_line, src_rxd, src_tout, src_txe, src_modem;

  assign trig_lvl  = FC_W'(trig_level(trig_sel));
  assign src_line  = ier[EN_LINE]  && ((err & LINE_SRC_MASK) != 8'h00);
  assign src_rxd   = ier[EN_RXD]   && data_ready && (rx_count >= trig_lvl);
  assign src_tout  = ier[EN_RXD]   && expired;
  assign src_txe   = ier[EN_TXE]   && thr_empty && pend;
  assign src_modem = ier[EN_MODEM] && (modem_delta != 4'h0);

  always_comb begin
    if (src_line)       code = IID_LINE;
    else if (src_rxd)   code = IID_RXD;
    else if (src_tout)  code = IID_TOUT;
    else if (src_txe)   code = IID_TXE;
    else if (src_modem) code = IID_MODEM;
    else                code = IID_NONE;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_iid_pkg::*;
#(
  parameter int TICK_DIV   = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int CT_W       = 16,
  parameter int TO_MULT    = 4,
  parameter int FC_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ier,
  input  logic [1:0]      trig_sel,
  input  logic [FC_W-1:0] rx_count,
  input  logic [7:0]      head_status,
  output logic            head_clr,
  input  logic [CT_W-1:0] char_time,
  input  logic            data_ready,
  input  logic            thr_empty,
  input  logic            tsr_empty,
  input  logic [3:0]      modem_delta,
  input  logic            tx_load,
  input  logic            rx_read,
  input  logic            lsr_read,
  input  logic            iid_read,
  output logic [7:0]      lsr,
  output logic [3:0]      iid,
  output logic            irq
);
  logic       tick, expired, pend_next, txe_ack;
  logic [7:0] err_next;
  iid_e       code, iid_q, iid_d;
  logic       irq_q, irq_d;

  uiu_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uiu_char_timer #(.CT_W(CT_W), .MULT(TO_MULT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .data_ready(data_ready),
    .rx_read(rx_read), .char_time(char_time), .expired(expired)
  );

  uiu_lsr_merge #(.FC_W(FC_W)) u_lsr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_count(rx_count),
    .head_status(head_status), .lsr_read(lsr_read),
    .data_ready(data_ready), .thr_empty(thr_empty), .tsr_empty(tsr_empty),
    .head_clr(head_clr), .err_next(err_next), .lsr(lsr)
  );

  assign txe_ack = iid_read && (iid_q == IID_TXE);

  uiu_tx_pend u_pend (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .ack(txe_ack),
    .pend_next(pend_next)
  );

  uiu_prio #(.FC_W(FC_W)) u_prio (
    .ier(ier), .err(err_next), .data_ready(data_ready),
    .thr_empty(thr_empty), .rx_count(rx_count), .trig_sel(trig_sel),
    .expired(expired), .pend(pend_next), .modem_delta(modem_delta),
    .code(code)
  );

  always_comb begin
    iid_d = iid_q;
    irq_d = irq_q;
    if (tick) begin
      iid_d = code;
      irq_d = (code != IID_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iid_q <= IID_NONE;
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= irq_d;
    end
  end

  assign iid = iid_q;
  assign irq = irq_q;

  // R1
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(iid) && $stable(irq)));

  // R2
  line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ier[EN_LINE] && ((err_next & LINE_SRC_MASK) != 8'h00))
      |=> (iid == IID_LINE));

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (iid != IID_NONE));

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;

  localparam int TICK_DIV = 16;
  localparam int FC_W     = 5;
  localparam int CT_W     = 16;
  localparam int TO_MULT  = 4;
  localparam int CNT_W    = CT_W + 3;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3:0]      ier;
  logic [1:0]      trig_sel;
  logic [FC_W-1:0] rx_count;
  logic [7:0]      head_status;
  logic            head_clr;
  logic [CT_W-1:0] char_time;
  logic            data_ready, thr_empty, tsr_empty;
  logic [3:0]      modem_delta;
  logic            tx_load, rx_read, lsr_read, iid_read;
  logic [7:0]      lsr;
  logic [3:0]      iid;
  logic            irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .ier(ier), .trig_sel(trig_sel),
    .rx_count(rx_count), .head_status(head_status), .head_clr(head_clr),
    .char_time(char_time), .data_ready(data_ready), .thr_empty(thr_empty),
    .tsr_empty(tsr_empty), .modem_delta(modem_delta), .tx_load(tx_load),
    .rx_read(rx_read), .lsr_read(lsr_read), .iid_read(iid_read),
    .lsr(lsr), .iid(iid), .irq(irq)
  );

  // reference model built from the requirements
  logic [4:0]       m_presc;
  logic [CNT_W-1:0] m_cnt, m_cnt_d;
  logic [7:0]       m_err, m_err_d;
  logic             m_pend, m_pend_d, m_tk;
  logic [3:0]       m_iid, m_code;
  logic             m_irq;

  function automatic logic [FC_W-1:0] ref_trig(input logic [1:0] s);
    case (s)
      2'd0: return 5'd1;
      2'd1: return 5'd4;
      2'd2: return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  always_comb begin
    m_tk = (m_presc == 5'(TICK_DIV - 1));
    m_cnt_d = m_cnt;
    if (rx_read) m_cnt_d = '0;
    else if (m_tk && data_ready && m_cnt != CMAX) m_cnt_d = m_cnt + 1'b1;
    m_err_d = (lsr_read ? 8'h00 : m_err) |
              ((m_tk && rx_count != 0) ? (head_status & 8'h9E) : 8'h00);
    m_pend_d = tx_load ? 1'b1 : ((iid_read && m_iid == 4'h2) ? 1'b0 : m_pend);
    if (ier[2] && (m_err_d & 8'h1E) != 0)                       m_code = 4'h6;
    else if (ier[0] && data_ready && rx_count >= ref_trig(trig_sel)) m_code = 4'h4;
    else if (ier[0] && m_cnt_d >= CNT_W'(char_time) * CNT_W'(TO_MULT)) m_code = 4'hC;
    else if (ier[1] && thr_empty && m_pend_d)                    m_code = 4'h2;
    else if (ier[3] && modem_delta != 0)                         m_code = 4'h0;
    else                                                         m_code = 4'h1;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_presc <= '0; m_cnt <= '0; m_err <= '0; m_pend <= 1'b0;
      m_iid <= 4'h1; m_irq <= 1'b0;
    end else begin
      m_presc <= m_tk ? 5'd0 : m_presc + 1'b1;
      m_cnt   <= m_cnt_d;
      m_err   <= m_err_d;
      m_pend  <= m_pend_d;
      if (m_tk) begin
        m_iid <= m_code;
        m_irq <= (m_code != 4'h1);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h6: return "R1 R3";
      4'h4: return "R1 R4";
      4'hC: return "R1 R5";
      4'h2: return "R1 R6";
      4'h0: return "R1 R7";
      default: return "R1 R10";
    endcase
  endfunction

  task automatic step();
    logic [7:0] exp_lsr;
    @(negedge clk);
    exp_lsr = (m_err & 8'h9E) | {1'b0, tsr_empty, thr_empty, 4'b0, data_ready};
    chk(32'(iid), 32'(m_iid), tag_of(m_iid));
    chk(32'(irq), 32'(m_irq), "R10 irq");
    chk(32'(lsr), 32'(exp_lsr), "R8 lsr view");
    chk(32'(head_clr), 32'(m_tk && rx_count != 0), "R8 head_clr");
  endtask

  task automatic run_to_tick();
    while (m_presc != 5'(TICK_DIV - 1)) step();
  endtask

  task automatic quiet();
    ier = 0; trig_sel = 0; rx_count = 0; head_status = 0; data_ready = 0;
    thr_empty = 0; tsr_empty = 0; modem_delta = 0; tx_load = 0;
    rx_read = 0; lsr_read = 0; iid_read = 0; char_time = 16'd100;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    quiet();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(32'(iid), 32'h1, "R11 iid");
    chk(32'(irq), 32'h0, "R11 irq");
    chk(32'(lsr), 32'h0, "R11 lsr");
    rst_n = 1'b1;

    // R2: every source active at once
    lsr_read = 1; step(); lsr_read = 0;
    run_to_tick();
    ier = 4'hF; head_status = 8'h02; rx_count = 14; trig_sel = 3;
    data_ready = 1; thr_empty = 1; modem_delta = 4'h1; tx_load = 1;
    step(); tx_load = 0; head_status = 0;
    chk(32'(iid), 32'h6, "R2 line highest");
    lsr_read = 1; step(); lsr_read = 0; rx_read = 1; step(); rx_read = 0;
    run_to_tick(); step();
    chk(32'(iid), 32'h4, "R2 receive data next");

    // R4 trigger boundary
    quiet(); lsr_read = 1; rx_read = 1; step(); lsr_read = 0; rx_read = 0;
    ier = 4'h1; data_ready = 1; trig_sel = 2; rx_count = 7; rx_read = 1;
    step(); rx_read = 0;
    run_to_tick(); step();
    chk(32'(iid), 32'h1, "R4 below trigger 8");
    rx_count = 8; run_to_tick(); step();
    chk(32'(iid), 32'h4, "R4 at trigger 8");

    // R5 timeout at 4 x char_time ticks
    quiet(); ier = 4'h1; data_ready = 1; char_time = 16'd2; rx_read = 1;
    step(); rx_read = 0;
    for (int k = 1; k <= 8; k++) begin
      run_to_tick(); step();
      if (k < 8) chk(32'(iid), 32'h1, "R5 before limit");
      else       chk(32'(iid), 32'hC, "R5 at limit");
    end
    rx_read = 1; step(); rx_read = 0; run_to_tick(); step();
    chk(32'(iid), 32'h1, "R5 cleared by rx_read");

    // R6 pending flag, set wins over ack
    quiet(); ier = 4'h2; thr_empty = 1; tx_load = 1; step(); tx_load = 0;
    run_to_tick(); step();
    chk(32'(iid), 32'h2, "R6 transmit empty");
    tx_load = 1; iid_read = 1; step(); tx_load = 0; iid_read = 0;
    run_to_tick(); step();
    chk(32'(iid), 32'h2, "R6 set wins");
    iid_read = 1; step(); iid_read = 0; run_to_tick(); step();
    chk(32'(iid), 32'h1, "R6 ack clears");

    // R9 merge and lsr_read in one clock
    quiet(); ier = 4'h4; rx_count = 3; head_status = 8'h08;
    run_to_tick(); lsr_read = 1; step(); lsr_read = 0;
    head_status = 0; rx_count = 0;
    chk(32'(lsr[3]), 32'h1, "R9 merge survives read");
    chk(32'(iid), 32'h6, "R9 line raised");
    lsr_read = 1; step(); lsr_read = 0;
    chk(32'(lsr[3]), 32'h0, "R9 read clears");
    // R8 ignored head bits
    rx_count = 2; head_status = 8'h61; run_to_tick(); step();
    head_status = 0; rx_count = 0;
    chk(32'(lsr), 32'h0, "R8 bits 0,5,6 ignored");

    // R7 modem, R1 hold
    quiet(); run_to_tick(); step();
    ier = 4'h8; modem_delta = 4'h4;
    if (m_presc != 5'(TICK_DIV - 1)) begin
      step(); chk(32'(iid), 32'h1, "R1 held until tick");
    end
    run_to_tick(); step();
    chk(32'(iid), 32'h0, "R7 modem");
    chk(32'(irq), 32'h1, "R7 irq");
    ier = 4'h0; run_to_tick(); step();
    chk(32'(irq), 32'h0, "R10 none");

    // random traffic
    quiet();
    for (int n = 0; n < 12000; n++) begin
      step();
      if (n % 64 == 0) begin
        ier = 4'($urandom_range(0, 15));
        trig_sel = 2'($urandom_range(0, 3));
        char_time = 16'($urandom_range(1, 4));
      end
      rx_count    = 5'($urandom_range(0, 16));
      head_status = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
      data_ready  = ($urandom_range(0, 3) != 0);
      thr_empty   = 1'($urandom);
      tsr_empty   = 1'($urandom);
      modem_delta = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      tx_load     = ($urandom_range(0, 9) == 0);
      rx_read     = ($urandom_range(0, 39) == 0);
      lsr_read    = ($urandom_range(0, 7) == 0);
      iid_read    = ($urandom_range(0, 5) == 0);
    end
    step();
    report();
  end

endmodule